// File: doc/BRIEF.md
# Dual-Rail Four-Valued Logic Unit

This block evaluates gate operations on vectors of four-valued signals. Each lane carries one of four values: logic zero, logic one, unknown (X) or conflict (T). A value travels on two Boolean rails. The first rail, `lo`, asserts "the value can be zero". The second rail, `hi`, asserts "the value can be one". Packed per lane as `{hi, lo}`, the codes are: zero `2'b01`, one `2'b10`, X `2'b00` and T `2'b11`. Lane `i` of a vector port occupies bits `[2*i+1 : 2*i]`.

The unit takes two operand vectors and an operation code. A registered result appears one cycle after each valid input. Alongside the result, the unit returns a per-lane unknown mask and a single flag that is high only when every lane holds a plain zero or one. The unit is meant for ternary-simulation accelerators and for X-tracking datapaths, where unknown and contradictory values have to be carried as values in their own right.

The operation codes are: 0 inverts operand A, 1 is AND, 2 is OR, and 3 joins the two operands under the information order. In that order X is the least value, zero and one lie above it, and T is the top.

Top module: `dr4_logic_unit`

## Requirements
- R1: Synchronous reset drives `out_valid` low and sets every result lane to X (`2'b00`).
- R2: Operation 0 inverts operand A lane by lane: zero becomes one, one becomes zero, X stays X and T stays T. Operand B has no effect on the result under this operation.
- R3: Operation 1 (AND): a zero on either operand gives zero, two ones give one, and any other mix without T gives X.
- R4: Operation 2 (OR): a one on either operand gives one, two zeros give zero, and any other mix without T gives X.
- R5: Under operations 1, 2 and 3, a lane in which either operand is T yields T. Under operation 0, a lane in which operand A is T yields T.
- R6: Operation 3 returns the least upper bound of the two operands: X joined with v gives v, a value joined with itself gives that value, zero joined with one gives T, and anything joined with T gives T.
- R7: When `in_valid` is high at a clock edge, the result for those inputs appears after that edge and `out_valid` is high for exactly that cycle. When `in_valid` is low, `out_valid` is low in the next cycle.
- R8: When `in_valid` is low at a clock edge, the registered result keeps its previous value, whatever the operands and operation code are.
- R9: `unknown_mask[i]` is high exactly when lane `i` of the registered result is X.
- R10: `all_defined` is high exactly when no lane of the registered result is X or T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op | input | 2 | Operation code: 0 invert A, 1 AND, 2 OR, 3 join |
| a_lanes | input | 2*LANES | Operand A, two rails per lane |
| b_lanes | input | 2*LANES | Operand B, two rails per lane |
| out_valid | output | 1 | Registered result was loaded at the last edge |
| result | output | 2*LANES | Registered result, two rails per lane |
| unknown_mask | output | LANES | Per-lane flag, high for X lanes of the result |
| all_defined | output | 1 | High when every result lane is zero or one |

## Verification
The result register is the block's only state, so a wrong value in it shows on `result`, `unknown_mask` and `all_defined` in the cycle right after the load edge. A stuck or mis-gated load enable shows in the next cycle after an idle input, as a result that changes when it should hold. Because every lane is checked against every value pair under every operation, a single wrong rail equation shows within one load. A missing T-forcing term shows as zero or one where T is expected.

// File: rtl/dr4_pkg.sv
package dr4_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } rail_t;

    typedef enum logic [1:0] {
        OP_NOT  = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_JOIN = 2'd3
    } op_e;

    localparam rail_t V_ZERO = '{hi: 1'b0, lo: 1'b1};
    localparam rail_t V_ONE  = '{hi: 1'b1, lo: 1'b0};
    localparam rail_t V_UNK  = '{hi: 1'b0, lo: 1'b0};
    localparam rail_t V_CONF = '{hi: 1'b1, lo: 1'b1};

    function automatic logic is_conflict(rail_t v);
        return v.hi & v.lo;
    endfunction

    function automatic logic is_unknown(rail_t v);
        return ~(v.hi | v.lo);
    endfunction

    function automatic logic is_defined(rail_t v);
        return v.hi ^ v.lo;
    endfunction

endpackage

// File: rtl/dr4_lane.sv
module dr4_lane
    import dr4_pkg::*;
(
    input  op_e   op,
    input  rail_t a,
    input  rail_t b,
    output rail_t y
);
    rail_t raw;
    logic  force_t;

    always_comb begin
        unique case (op)
            OP_NOT:  raw = '{hi: a.lo,        lo: a.hi};
            OP_AND:  raw = '{hi: a.hi & b.hi, lo: a.lo | b.lo};
            OP_OR:   raw = '{hi: a.hi | b.hi, lo: a.lo & b.lo};
            default: raw = '{hi: a.hi | b.hi, lo: a.lo | b.lo};
        endcase
    end

    // Plain rail algebra lets a zero or one mask a conflict; forbid that.
    assign force_t = is_conflict(a) | ((op != OP_NOT) & is_conflict(b));
    assign y       = force_t ? V_CONF : raw;

    always_comb begin
        if (force_t) begin
            a_r5_conflict_wins: assert (is_conflict(y));
        end
    end

endmodule

// File: rtl/dr4_outreg.sv
module dr4_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         q_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!q_valid && q == '0));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/dr4_logic_unit.sv
module dr4_logic_unit
    import dr4_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         op,
    input  logic [2*LANES-1:0] a_lanes,
    input  logic [2*LANES-1:0] b_lanes,
    output logic               out_valid,
    output logic [2*LANES-1:0] result,
    output logic [LANES-1:0]   unknown_mask,
    output logic               all_defined
);
    localparam int VW = 2 * LANES;

    op_e              op_q;
    logic [VW-1:0]    next_vec;
    logic [LANES-1:0] lane_def;

    assign op_q = op_e'(op);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rail_t la, lb, ly, lr;
        assign la = rail_t'(a_lanes[2*i +: 2]);
        assign lb = rail_t'(b_lanes[2*i +: 2]);

        dr4_lane u_lane (
            .op (op_q),
            .a  (la),
            .b  (lb),
            .y  (ly)
        );

        assign next_vec[2*i +: 2] = ly;
        assign lr                 = rail_t'(result[2*i +: 2]);
        assign unknown_mask[i]    = is_unknown(lr);
        assign lane_def[i]        = is_defined(lr);
    end

    assign all_defined = &lane_def;

    dr4_outreg #(.W(VW)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (next_vec),
        .q       (result),
        .q_valid (out_valid)
    );

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_defined_has_no_x: assert property (@(posedge clk) disable iff (rst)
        all_defined |-> (unknown_mask == '0));

endmodule

// File: tb/sim_dr4_logic_unit.sv
`timescale 1ns/1ps
module sim_dr4_logic_unit;
    localparam int LANES = 4;
    localparam int VW    = 2 * LANES;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [1:0]       op;
    logic [VW-1:0]    a_lanes, b_lanes;
    logic             out_valid;
    logic [VW-1:0]    result;
    logic [LANES-1:0] unknown_mask;
    logic             all_defined;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dr4_logic_unit #(.LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .a_lanes(a_lanes), .b_lanes(b_lanes), .out_valid(out_valid),
        .result(result), .unknown_mask(unknown_mask), .all_defined(all_defined)
    );

    // value codes: 0 zero, 1 one, 2 X, 3 T
    function automatic logic [1:0] enc(int v);
        case (v)
            0: return 2'b01;
            1: return 2'b10;
            2: return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    function automatic int model(int o, int x, int y);
        if (o == 0) begin
            if (x == 3) return 3;
            if (x == 2) return 2;
            return 1 - x;
        end
        if (x == 3 || y == 3) return 3;
        if (o == 1) begin
            if (x == 0 || y == 0) return 0;
            if (x == 1 && y == 1) return 1;
            return 2;
        end
        if (o == 2) begin
            if (x == 1 || y == 1) return 1;
            if (x == 0 && y == 0) return 0;
            return 2;
        end
        if (x == 2) return y;
        if (y == 2) return x;
        if (x == y) return x;
        return 3;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0]    exp_v;
        logic [LANES-1:0] exp_m;
        logic             exp_d;
        string            tag;
        logic             has_t;

        rst = 1'b1; in_valid = 1'b0; op = 2'd0;
        a_lanes = '1; b_lanes = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", {24'd0, result}, 32'd0);
        check("R9 mask after reset", {28'd0, unknown_mask}, 32'hF);
        check("R10 flag after reset", {31'd0, all_defined}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int o = 0; o < 4; o++) begin
            for (int pa = 0; pa < 4; pa++) begin
                for (int pb = 0; pb < 4; pb++) begin
                    has_t = 1'b0;
                    exp_d = 1'b1;
                    for (int i = 0; i < LANES; i++) begin
                        int va, vb, r;
                        va = (pa + i) % 4;
                        vb = (pb + 3 * i) % 4;
                        a_lanes[2*i +: 2] = enc(va);
                        b_lanes[2*i +: 2] = enc(vb);
                        r = model(o, va, vb);
                        exp_v[2*i +: 2] = enc(r);
                        exp_m[i] = (r == 2);
                        if (r > 1) exp_d = 1'b0;
                        if (va == 3 || (o != 0 && vb == 3)) has_t = 1'b1;
                    end
                    case (o)
                        0: tag = has_t ? "R2/R5 invert" : "R2 invert";
                        1: tag = has_t ? "R3/R5 and" : "R3 and";
                        2: tag = has_t ? "R4/R5 or" : "R4 or";
                        default: tag = has_t ? "R6/R5 join" : "R6 join";
                    endcase
                    op = o[1:0];
                    in_valid = 1'b1;
                    @(negedge clk);
                    check(tag, {24'd0, result}, {24'd0, exp_v});
                    check("R7 valid high", {31'd0, out_valid}, 32'd1);
                    check("R9 mask", {28'd0, unknown_mask}, {28'd0, exp_m});
                    check("R10 flag", {31'd0, all_defined}, {31'd0, exp_d});
                    if (pb == 3) begin
                        // R8: idle cycle with different operands must not load
                        in_valid = 1'b0;
                        a_lanes = ~a_lanes;
                        b_lanes = ~b_lanes;
                        op = op + 2'd1;
                        @(negedge clk);
                        check("R8 hold", {24'd0, result}, {24'd0, exp_v});
                        check("R7 valid low", {31'd0, out_valid}, 32'd0);
                    end
                end
            end
        end

        // R10 and R2: fully defined vector; invert ignores B (B all T)
        in_valid = 1'b1; op = 2'd0;
        a_lanes = {2'b01, 2'b10, 2'b10, 2'b01};
        b_lanes = '1;
        @(negedge clk);
        check("R2 B ignored", {24'd0, result}, {24'd0, 8'b10_01_01_10});
        check("R10 all defined", {31'd0, all_defined}, 32'd1);
        check("R9 no unknown", {28'd0, unknown_mask}, 32'd0);

        // R1: reset mid-run clears result again
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R1 reset again", {24'd0, result}, 32'd0);
        check("R1 valid again", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end
endmodule